// File: doc/BRIEF.md
# Multiplexed-Bus One-Time-Programmable ROM

This block is a synthesizable, clocked model of a byte-wide, one-time-programmable read-only memory that sits on a multiplexed bus. One 8-bit bidirectional port carries the low address byte during the address phase and the data byte during the data phase. In the model this port is split into a port input, a port output and an output-enable. The high address byte has its own input pins.

A strobe input captures the low address into an internal latch. The operating mode is decoded from four inputs: the strobe, an active-low output-enable line, a flag meaning that line is held at programming voltage, and a flag meaning address bit 9 is held at high voltage. The supported modes are read, output disable, standby, program and product identification.

Programming can only clear bits. A cell starts at 0xFF, and each program pulse ANDs the stored byte with the port byte. The array depth is a parameter so that simulation can use a smaller array. When the depth is smaller than 64K, the upper address bits are dropped and the address wraps.

Top module: `mux_otp_rom`

## Requirements
- R1: After synchronous reset the port output-enable is low and every cell reads 0xFF.
- R2: While the strobe is high and the program flag is clear, the latch takes the port value on each clock. After the strobe falls, later port values do not change the address used.
- R3: When the strobe is high and the program flag is clear, the block is in standby. One clock later the port is not driven, even if the output-enable line and the identification flag are asserted.
- R4: With the strobe low, the output-enable line low and both flags clear, the port is driven one clock later with the byte at {high address, latched low address}.
- R5: With the strobe low, the output-enable line high and the program flag clear, the port is not driven one clock later.
- R6: With the identification flag set and read conditions otherwise met, the port is driven one clock later with 0x1E when high-address bit 0 is 0 and with 0x9D when it is 1.
- R7: While the program flag is set, each rising edge of the strobe writes the port byte to the latched address. While the program flag is set, the port is never driven.
- R8: A program pulse stores the old byte ANDed with the port byte, so a cleared bit stays cleared and a pulse carrying 0xFF changes nothing.
- R9: While the program flag is set, strobe pulses do not load the latch. The address latched before programming is still in use afterwards.
- R10: With an array of DEPTH bytes, only the low log2(DEPTH) bits of the 16-bit address select a cell. The default DEPTH is 1024, so high-address bits 7..2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Address-latch strobe, also the program pulse |
| oe_n_i | input | 1 | Active-low output-enable line |
| vpp_i | input | 1 | Output-enable line held at programming voltage |
| a9_hv_i | input | 1 | Address bit 9 held at high voltage (identification) |
| addr_hi_i | input | 8 | Address bits 15..8 |
| port_i | input | 8 | Shared port, input direction (low address or write data) |
| port_o | output | 8 | Shared port, output direction (read data) |
| port_oe_o | output | 1 | Shared port driver enable |

## Verification
The assertions assume the inputs are stable around the rising clock edge. They also assume that a rising edge of the strobe counts as one program pulse only while the program flag is already set. The stimulus changes inputs only on the falling clock edge. It raises the program flag one clock before the strobe pulse and lowers it one clock after the pulse ends. It changes the port value only while the strobe is high or after the strobe has fallen, never in the same half-cycle as the strobe edge.

// File: rtl/otp_rom_pkg.sv
// Package: shared mode type and identification bytes for the multiplexed OTP ROM.
package otp_rom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_DISABLE,
        MODE_READ,
        MODE_IDENT,
        MODE_PROGRAM
    } rom_mode_e;

    localparam logic [7:0] MFR_CODE = 8'h1E;
    localparam logic [7:0] DEV_CODE = 8'h9D;

endpackage

// File: rtl/otp_addr_latch.sv
// Low-address latch. It loads the shared port value on every clock while
// cap_i is high and holds that value otherwise.
// Assumes: cap_i is already qualified by the caller (strobe high, not programming).
module otp_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Capture the port while the strobe is open, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= '0;
        else if (cap_i) q_o <= d_i;
    end

    assert_latch_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_i) |-> (q_o == $past(d_i)));

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_i) |-> $stable(q_o));

endmodule

// File: rtl/otp_mode_decode.sv
// Mode decoder. It maps strobe, output-enable and the two high-voltage flags
// to one operating mode.
// Priority: program flag, then strobe (standby), then output-enable, then
// identification flag, then read.
module otp_mode_decode
    import otp_rom_pkg::*;
(
    input  logic      strobe_i,
    input  logic      oe_n_i,
    input  logic      vpp_i,
    input  logic      a9_hv_i,
    output rom_mode_e mode_o
);

    // Priority decode of the operating mode.
    always_comb begin
        if (vpp_i)         mode_o = MODE_PROGRAM;
        else if (strobe_i) mode_o = MODE_STANDBY;
        else if (oe_n_i)   mode_o = MODE_DISABLE;
        else if (a9_hv_i)  mode_o = MODE_IDENT;
        else               mode_o = MODE_READ;
    end

endmodule

// File: rtl/otp_cell_array.sv
// Byte array with one-way programming. Reset sets every cell to 0xFF. A write
// ANDs the stored byte with the write data, so bits can only be cleared.
// The read port is combinational.
// Assumes: DEPTH equals 2**AW.
module otp_cell_array #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx_i,
    output logic [7:0]    rd_data_o,
    input  logic          we_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [7:0]    wr_data_i
);

    logic [7:0] mem_q [DEPTH];

    // Erase on reset; clear-only update on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we_i) begin
            mem_q[wr_idx_i] <= mem_q[wr_idx_i] & wr_data_i;
        end
    end

    // Combinational read of the addressed cell.
    assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/mux_otp_rom.sv
// Multiplexed-bus one-time-programmable ROM model. Ties together the
// low-address latch, the mode decoder and the cell array, and registers
// the port output.
// Assumes: inputs are synchronous to clk; the high-voltage conditions are
// given as flags.
module mux_otp_rom
    import otp_rom_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    input  logic       oe_n_i,
    input  logic       vpp_i,
    input  logic       a9_hv_i,
    input  logic [7:0] addr_hi_i,
    input  logic [7:0] port_i,
    output logic [7:0] port_o,
    output logic       port_oe_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    lat_lo;
    logic [15:0]   full_addr;
    logic [AW-1:0] cell_idx;
    logic [7:0]    cell_data;
    logic          strobe_q;
    logic          prog_we;
    rom_mode_e     mode;

    otp_addr_latch #(.W(8)) lat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (strobe_i && !vpp_i),
        .d_i   (port_i),
        .q_o   (lat_lo)
    );

    otp_mode_decode dec_i (
        .strobe_i (strobe_i),
        .oe_n_i   (oe_n_i),
        .vpp_i    (vpp_i),
        .a9_hv_i  (a9_hv_i),
        .mode_o   (mode)
    );

    // Form the cell index from the pins and the latch (upper bits wrap).
    assign full_addr = {addr_hi_i, lat_lo};
    assign cell_idx  = full_addr[AW-1:0];

    // A program pulse is a rising strobe while the program flag is set.
    assign prog_we = rst_n && (mode == MODE_PROGRAM) && strobe_i && !strobe_q;

    otp_cell_array #(.DEPTH(DEPTH), .AW(AW)) arr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (cell_idx),
        .rd_data_o (cell_data),
        .we_i      (prog_we),
        .wr_idx_i  (cell_idx),
        .wr_data_i (port_i)
    );

    // Remember the strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    // Register the port driver from the decoded mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_o    <= 8'h00;
            port_oe_o <= 1'b0;
        end else begin
            unique case (mode)
                MODE_READ: begin
                    port_o    <= cell_data;
                    port_oe_o <= 1'b1;
                end
                MODE_IDENT: begin
                    port_o    <= addr_hi_i[0] ? DEV_CODE : MFR_CODE;
                    port_oe_o <= 1'b1;
                end
                default: begin
                    port_o    <= 8'h00;
                    port_oe_o <= 1'b0;
                end
            endcase
        end
    end

    assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strobe_i) |-> !port_oe_o);

    assert_disable_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!strobe_i && oe_n_i && !vpp_i) |-> !port_oe_o);

    assert_prog_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vpp_i) |-> !port_oe_o);

    assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!strobe_i && !oe_n_i && !vpp_i) |-> port_oe_o);

    assert_ident_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!strobe_i && !oe_n_i && !vpp_i && a9_hv_i)
        |-> (port_o == ($past(addr_hi_i[0]) ? 8'h9D : 8'h1E)));

endmodule

// File: tb/mux_otp_rom_tb_top.sv
// Directed bench for mux_otp_rom: one task per scenario. Inputs are driven
// on the falling clock edge and outputs are sampled there.
module mux_otp_rom_tb_top;

    localparam int DEPTH = 1024;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       strobe, oe_n, vpp, a9_hv;
    logic [7:0] addr_hi, port_in;
    logic [7:0] port_out;
    logic       port_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    mux_otp_rom #(.DEPTH(DEPTH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (strobe),
        .oe_n_i    (oe_n),
        .vpp_i     (vpp),
        .a9_hv_i   (a9_hv),
        .addr_hi_i (addr_hi),
        .port_i    (port_in),
        .port_o    (port_out),
        .port_oe_o (port_oe)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Latch a low address, then move the port to 0x00 to show later values are ignored.
    task automatic latch_addr(logic [7:0] lo);
        vpp = 0; oe_n = 1; strobe = 1; port_in = lo;
        step();
        strobe = 0; port_in = 8'h00;
        step();
    endtask

    // Read with the current latch; returns {oe, data}.
    task automatic read_cur(logic [7:0] hi, output logic [8:0] r);
        addr_hi = hi; oe_n = 0; a9_hv = 0;
        step();
        r = {port_oe, port_out};
        oe_n = 1;
        step();
    endtask

    task automatic read_at(logic [7:0] hi, logic [7:0] lo, output logic [8:0] r);
        latch_addr(lo);
        read_cur(hi, r);
    endtask

    // Program one byte: latch, raise program flag, one strobe pulse, lower flag.
    task automatic program_byte(logic [7:0] hi, logic [7:0] lo, logic [7:0] d);
        latch_addr(lo);
        addr_hi = hi; oe_n = 0; vpp = 1;
        step();
        strobe = 1; port_in = d;
        step();
        chk("R7 no drive while programming", {8'h00, port_oe}, 9'h000);
        strobe = 0;
        step();
        vpp = 0; oe_n = 1;
        step();
    endtask

    task automatic t_reset();
        logic [8:0] r;
        chk("R1 oe after reset", {8'h00, port_oe}, 9'h000);
        read_at(8'h00, 8'h37, r);
        chk("R1 erased cell", r, 9'h1FF);
        read_at(8'h03, 8'hFF, r);
        chk("R1 erased top cell", r, 9'h1FF);
    endtask

    task automatic t_standby();
        strobe = 1; oe_n = 0; a9_hv = 1; port_in = 8'h11;
        step();
        chk("R3 standby not driven", {8'h00, port_oe}, 9'h000);
        strobe = 0; a9_hv = 0; oe_n = 1;
        step();
    endtask

    task automatic t_disable();
        strobe = 0; oe_n = 1; vpp = 0;
        step();
        chk("R5 disabled not driven", {8'h00, port_oe}, 9'h000);
    endtask

    task automatic t_ident();
        strobe = 0; vpp = 0; oe_n = 0; a9_hv = 1; addr_hi = 8'h00;
        step();
        chk("R6 manufacturer code", {port_oe, port_out}, 9'h11E);
        addr_hi = 8'h01;
        step();
        chk("R6 device code", {port_oe, port_out}, 9'h19D);
        a9_hv = 0; oe_n = 1;
        step();
    endtask

    task automatic t_program();
        logic [8:0] r;
        program_byte(8'h01, 8'h20, 8'hA5);
        read_at(8'h01, 8'h20, r);
        chk("R7 R4 programmed byte read back", r, 9'h1A5);
        read_at(8'h01, 8'h00, r);
        chk("R2 port value after strobe fall ignored", r, 9'h1FF);
    endtask

    task automatic t_and_only();
        logic [8:0] r;
        program_byte(8'h02, 8'h44, 8'hF0);
        program_byte(8'h02, 8'h44, 8'hFF);
        read_at(8'h02, 8'h44, r);
        chk("R8 0xFF pulse changes nothing", r, 9'h1F0);
        program_byte(8'h02, 8'h44, 8'h3C);
        read_at(8'h02, 8'h44, r);
        chk("R8 AND of 0xF0 and 0x3C", r, 9'h130);
        program_byte(8'h01, 8'h20, 8'h5A);
        read_at(8'h01, 8'h20, r);
        chk("R8 cleared bits stay cleared", r, 9'h100);
    endtask

    task automatic t_latch_frozen();
        logic [8:0] r;
        latch_addr(8'h40);
        addr_hi = 8'h00; vpp = 1;
        step();
        strobe = 1; port_in = 8'h77;
        step();
        strobe = 0;
        step();
        vpp = 0;
        step();
        read_cur(8'h00, r);
        chk("R9 latch held through program pulse", r, 9'h177);
        read_at(8'h00, 8'h77, r);
        chk("R9 other address untouched", r, 9'h1FF);
    endtask

    task automatic t_alias();
        logic [8:0] r;
        read_at(8'h05, 8'h20, r);
        chk("R10 upper high bits ignored", r, 9'h100);
        read_at(8'hFE, 8'h44, r);
        chk("R10 wrap of 0xFE44 to cell 0x244", r, 9'h130);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 0; strobe = 0; oe_n = 1; vpp = 0; a9_hv = 0;
        addr_hi = 8'h00; port_in = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_standby();
        t_disable();
        t_ident();
        t_program();
        t_and_only();
        t_latch_frozen();
        t_alias();
        done = 1'b1;
        report();
        $finish;
    end

endmodule